// File: doc/BRIEF.md
# GPIO Edge Interrupt Status and Bank Aggregator

This block watches 32 already-synchronized general-purpose input pins for edges and turns them into interrupts. Each pin has its own rising-edge enable and falling-edge enable. Each enable is changed through a pair of write-only-ones registers, one that sets bits and one that clears them. A detected edge on an enabled pin sets a sticky bit in an interrupt status register, which software clears by writing ones.

The status word is split into a lower and an upper 16-pin half. Each half drives one level-sensitive bank interrupt line. A global bank-enable register has one bit per half and gates that line. The lowest few pins also drive direct per-pin interrupt outputs straight from their status bits, so an interrupt controller can take them without a demultiplexing step. Writes are single-cycle strobes. Reads are combinational from the read address.

Top module: `gpio_edge_irq_agg`

## Requirements
- R1: Writing to byte offset 0x14 ORs the written bits into the rising-edge enable mask, and writing to 0x18 clears the written bits from it. Offsets 0x1C (set) and 0x20 (clear) do the same for the falling-edge mask. Zero bits leave the mask unchanged, and reading either offset of a pair returns the current mask.
- R2: A pin with only its rising enable sets its status bit on a 0-to-1 change only, and a pin with only its falling enable on a 1-to-0 change only. A pin with neither enable never sets its status bit.
- R3: A pin with both enables set raises its status bit on either edge.
- R4: The status register at byte offset 0x24 reads back the latched events. Writing it clears exactly the bits written as 1, and bits written as 0 stay unchanged.
- R5: Status bits 0 to 15 drive bank_irq[0] and status bits 16 to 31 drive bank_irq[1].
- R6: The bank-enable register at byte offset 0x08 holds one bit per bank in bits [1:0] and reads back the same way. A bank line is low whenever its bit is 0.
- R7: A bank line is a level: it stays high while its bank is enabled and any status bit of its half is set. It re-asserts when a new event arrives after the bits were cleared.
- R8: pin_irq[i] equals status bit i for the lowest DIRECT_PINS pins (default 4), whatever the bank enables are.
- R9: If an edge event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R10: After reset, all edge enables, status bits and bank enables are zero, and both bank lines and all direct outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| bank_irq | output | 2 | Level interrupt per 16-pin bank |
| pin_irq | output | 4 | Direct interrupt for the lowest pins |

## Verification
A register write takes effect at the first rising edge after the strobe. A pin change is compared with the delayed copy of the pin in the same cycle, so the matching status bit is set at that same first edge. The bank lines, the direct outputs and the read data follow combinationally from the registers and change in the cycle after that edge. The bench drives every input at a falling edge and samples at the next falling edge, which is exactly one rising edge later. The one exception is the collision case, where an edge and a clear are presented in the same cycle on purpose.

// File: rtl/gei_pkg.sv
package gei_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_BANK_EN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_RISE_SET = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_FALL_SET = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h24;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_RISE_SET,
        CMD_RISE_CLR,
        CMD_FALL_SET,
        CMD_FALL_CLR,
        CMD_STAT_W1C,
        CMD_BANK_EN
    } wr_cmd_e;

    typedef struct packed {
        wr_cmd_e          cmd;
        logic [REG_W-1:0] data;
    } wr_req_t;

    function automatic wr_cmd_e decode_write(input logic [ADDR_W-1:0] addr);
        case (addr)
            OFS_RISE_SET: return CMD_RISE_SET;
            OFS_RISE_CLR: return CMD_RISE_CLR;
            OFS_FALL_SET: return CMD_FALL_SET;
            OFS_FALL_CLR: return CMD_FALL_CLR;
            OFS_STATUS:   return CMD_STAT_W1C;
            OFS_BANK_EN:  return CMD_BANK_EN;
            default:      return CMD_NONE;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] set_clr(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] set_m,
                                                 input logic [REG_W-1:0] clr_m);
        return (cur | set_m) & ~clr_m;
    endfunction

endpackage

// File: rtl/gei_edge_cfg.sv
module gei_edge_cfg
    import gei_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  wr_req_t         req,
    output logic [PINS-1:0] rise_en,
    output logic [PINS-1:0] fall_en
);

    logic [REG_W-1:0] rise_set, rise_clr, fall_set, fall_clr;
    logic [REG_W-1:0] rise_nxt, fall_nxt;

    always_comb begin
        rise_set = (req.cmd == CMD_RISE_SET) ? req.data : '0;
        rise_clr = (req.cmd == CMD_RISE_CLR) ? req.data : '0;
        fall_set = (req.cmd == CMD_FALL_SET) ? req.data : '0;
        fall_clr = (req.cmd == CMD_FALL_CLR) ? req.data : '0;
        rise_nxt = set_clr(REG_W'(rise_en), rise_set, rise_clr);
        fall_nxt = set_clr(REG_W'(fall_en), fall_set, fall_clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_en <= '0;
            fall_en <= '0;
        end else begin
            rise_en <= rise_nxt[PINS-1:0];
            fall_en <= fall_nxt[PINS-1:0];
        end
    end

    // R1: set register turns selected bits on
    assert_rise_set_R1: assert property (@(posedge clk) disable iff (rst)
        (req.cmd == CMD_RISE_SET) |=>
        ((rise_en & $past(req.data[PINS-1:0])) == $past(req.data[PINS-1:0])));

    // R1: clear register turns selected bits off
    assert_fall_clr_R1: assert property (@(posedge clk) disable iff (rst)
        (req.cmd == CMD_FALL_CLR) |=> ((fall_en & $past(req.data[PINS-1:0])) == '0));

    // R1: masks hold when no enable register is written
    assert_en_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (req.cmd inside {CMD_NONE, CMD_STAT_W1C, CMD_BANK_EN}) |=>
        ($stable(rise_en) && $stable(fall_en)));

endmodule

// File: rtl/gei_edge_detect.sv
module gei_edge_detect #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pin_in,
    input  logic [PINS-1:0] rise_en,
    input  logic [PINS-1:0] fall_en,
    output logic [PINS-1:0] evt
);

    logic [PINS-1:0] pin_d;

    always_ff @(posedge clk) begin
        if (rst) pin_d <= '0;
        else     pin_d <= pin_in;
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic went_up, went_down;
        assign went_up   = pin_in[i] & ~pin_d[i];
        assign went_down = ~pin_in[i] & pin_d[i];
        assign evt[i]    = (went_up & rise_en[i]) | (went_down & fall_en[i]);
    end

    // R2: a pin whose level did not move produces no event
    assert_no_evt_without_change_R2: assert property (@(posedge clk) disable iff (rst)
        ((evt & ~(pin_in ^ pin_d)) == '0));

endmodule

// File: rtl/gei_status.sv
module gei_status #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] evt,
    input  logic            clr_valid,
    input  logic [PINS-1:0] clr_mask,
    output logic [PINS-1:0] status
);

    logic [PINS-1:0] clr_eff;

    assign clr_eff = clr_valid ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_eff) | evt;
    end

    // R9: an event is latched even when the same bit is being cleared
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

    // R4: cleared bits drop unless a new event arrived
    assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
        clr_valid |=> ((status & $past(clr_mask) & ~$past(evt)) == '0));

    // R4: status is sticky without events or clears
    assert_status_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr_valid && evt == '0) |=> $stable(status));

endmodule

// File: rtl/gei_bank_merge.sv
module gei_bank_merge #(
    parameter int PINS   = 32,
    parameter int BANK_W = 16,
    localparam int NUM_BANKS = PINS / BANK_W
) (
    input  logic [PINS-1:0]      status,
    input  logic [NUM_BANKS-1:0] bank_en,
    output logic [NUM_BANKS-1:0] bank_irq
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic any_set;
        assign any_set     = |status[b*BANK_W +: BANK_W];
        assign bank_irq[b] = any_set & bank_en[b];
    end

endmodule

// File: rtl/gpio_edge_irq_agg.sv
module gpio_edge_irq_agg
    import gei_pkg::*;
#(
    parameter int PINS        = 32,
    parameter int BANK_W      = 16,
    parameter int DIRECT_PINS = 4,
    localparam int NUM_BANKS  = PINS / BANK_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PINS-1:0]        pin_in,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [REG_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [REG_W-1:0]       rd_data,
    output logic [NUM_BANKS-1:0]   bank_irq,
    output logic [DIRECT_PINS-1:0] pin_irq
);

    wr_req_t               req;
    logic [PINS-1:0]       rise_en, fall_en, evt, status;
    logic [NUM_BANKS-1:0]  bank_en;

    always_comb begin
        req.cmd  = wr_en ? decode_write(wr_addr) : CMD_NONE;
        req.data = wr_data;
    end

    gei_edge_cfg #(.PINS(PINS)) u_cfg (
        .clk(clk), .rst(rst), .req(req), .rise_en(rise_en), .fall_en(fall_en)
    );

    gei_edge_detect #(.PINS(PINS)) u_det (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .rise_en(rise_en), .fall_en(fall_en), .evt(evt)
    );

    gei_status #(.PINS(PINS)) u_stat (
        .clk(clk), .rst(rst), .evt(evt),
        .clr_valid(req.cmd == CMD_STAT_W1C),
        .clr_mask(req.data[PINS-1:0]),
        .status(status)
    );

    always_ff @(posedge clk) begin
        if (rst)                      bank_en <= '0;
        else if (req.cmd == CMD_BANK_EN) bank_en <= req.data[NUM_BANKS-1:0];
    end

    gei_bank_merge #(.PINS(PINS), .BANK_W(BANK_W)) u_merge (
        .status(status), .bank_en(bank_en), .bank_irq(bank_irq)
    );

    for (genvar i = 0; i < DIRECT_PINS; i++) begin : g_direct
        assign pin_irq[i] = status[i];

        // R8: an event on a direct pin shows on its output next cycle
        assert_direct_follow_R8: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> pin_irq[i]);
    end

    always_comb begin
        case (rd_addr)
            OFS_RISE_SET, OFS_RISE_CLR: rd_data = REG_W'(rise_en);
            OFS_FALL_SET, OFS_FALL_CLR: rd_data = REG_W'(fall_en);
            OFS_STATUS:                 rd_data = REG_W'(status);
            OFS_BANK_EN:                rd_data = REG_W'(bank_en);
            default:                    rd_data = '0;
        endcase
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        // R6: a disabled bank never signals
        assert_bank_gate_R6: assert property (@(posedge clk) disable iff (rst)
            !bank_en[b] |-> !bank_irq[b]);

        // R7: an enabled bank with pending status holds its line high
        assert_bank_level_R7: assert property (@(posedge clk) disable iff (rst)
            (bank_en[b] && status[b*BANK_W +: BANK_W] != '0) |-> bank_irq[b]);
    end

    // R10: reset leaves every output quiet on the next cycle
    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (bank_irq == '0 && pin_irq == '0));

endmodule

// File: tb/tb_gpio_edge_irq_agg.sv
module tb_gpio_edge_irq_agg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pin_in = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  bank_irq;
    logic [3:0]  pin_irq;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [7:0] A_BEN = 8'h08, A_RS = 8'h14, A_RC = 8'h18,
                           A_FS = 8'h1C, A_FC = 8'h20, A_ST = 8'h24;

    always #4 clk = ~clk;

    gpio_edge_irq_agg dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .bank_irq(bank_irq), .pin_irq(pin_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        rd_chk("R10 rise mask", A_RS, 32'h0);
        rd_chk("R10 fall mask", A_FC, 32'h0);
        rd_chk("R10 status", A_ST, 32'h0);
        rd_chk("R10 bank enable", A_BEN, 32'h0);
        check("R10 bank_irq", 32'(bank_irq), 32'h0);
        check("R10 pin_irq", 32'(pin_irq), 32'h0);
    endtask

    task automatic t_enables();
        wr(A_RS, 32'h0010_0009);
        rd_chk("R1 rise set", A_RS, 32'h0010_0009);
        rd_chk("R1 rise read at clear offset", A_RC, 32'h0010_0009);
        wr(A_RC, 32'h0000_0001);
        rd_chk("R1 rise clear", A_RS, 32'h0010_0008);
        wr(A_RS, 32'h0);
        rd_chk("R1 zero set no effect", A_RS, 32'h0010_0008);
        wr(A_FS, 32'h0000_0006);
        wr(A_FC, 32'h0000_0002);
        rd_chk("R1 fall set/clear", A_FS, 32'h0000_0004);
        wr(A_RC, 32'h0);
        rd_chk("R1 zero clear no effect", A_RS, 32'h0010_0008);
    endtask

    task automatic t_single_edges();
        pins(32'h0000_0008);
        rd_chk("R2 rising on rise-only pin", A_ST, 32'h0000_0008);
        pins(32'h0000_0000);
        rd_chk("R2 falling ignored on rise-only pin", A_ST, 32'h0000_0008);
        pins(32'h0000_0020);
        pins(32'h0000_0000);
        rd_chk("R2 disabled pin ignored", A_ST, 32'h0000_0008);
        wr(A_ST, 32'hFFFF_FFFF);
        pins(32'h0000_0004);
        rd_chk("R2 rising ignored on fall-only pin", A_ST, 32'h0);
        pins(32'h0000_0000);
        rd_chk("R2 falling on fall-only pin", A_ST, 32'h0000_0004);
        wr(A_ST, 32'hFFFF_FFFF);
    endtask

    task automatic t_both_edges();
        wr(A_FS, 32'h0000_0008);
        pins(32'h0000_0008);
        rd_chk("R3 both: rising", A_ST, 32'h0000_0008);
        wr(A_ST, 32'h0000_0008);
        pins(32'h0000_0000);
        rd_chk("R3 both: falling", A_ST, 32'h0000_0008);
        wr(A_ST, 32'hFFFF_FFFF);
    endtask

    task automatic t_w1c();
        pins(32'h0010_0008);
        rd_chk("R4 two events latched", A_ST, 32'h0010_0008);
        wr(A_ST, 32'h0000_0008);
        rd_chk("R4 clear only written ones", A_ST, 32'h0010_0000);
        wr(A_ST, 32'h0);
        rd_chk("R4 zero write keeps bits", A_ST, 32'h0010_0000);
    endtask

    task automatic t_banks();
        check("R6 disabled banks low", 32'(bank_irq), 32'h0);
        wr(A_BEN, 32'h2);
        rd_chk("R6 bank enable readback", A_BEN, 32'h2);
        check("R5 upper half drives bank 1", 32'(bank_irq), 32'h2);
        wr(A_BEN, 32'h3);
        check("R5 empty lower half keeps bank 0 low", 32'(bank_irq), 32'h2);
        pins(32'h0010_0000);
        check("R5 pin 3 drives bank 0", 32'(bank_irq), 32'h3);
    endtask

    task automatic t_level();
        wr(A_ST, 32'h0010_0000);
        check("R7 bank 0 holds with bit 3 pending", 32'(bank_irq), 32'h1);
        wr(A_BEN, 32'h0);
        check("R6 disable gates pending status", 32'(bank_irq), 32'h0);
        wr(A_BEN, 32'h3);
        check("R7 re-enable shows pending level", 32'(bank_irq), 32'h1);
        wr(A_ST, 32'h0000_0008);
        check("R7 line drops when half empty", 32'(bank_irq), 32'h0);
        pins(32'h0010_0008);
        check("R7 new event re-asserts", 32'(bank_irq), 32'h1);
    endtask

    task automatic t_direct();
        check("R8 direct output pin 3", 32'(pin_irq), 32'h8);
        pins(32'h0010_000C);
        pins(32'h0010_0008);
        check("R8 direct output pins 2 and 3", 32'(pin_irq), 32'hC);
        wr(A_BEN, 32'h0);
        check("R8 direct independent of bank enable", 32'(pin_irq), 32'hC);
        check("R8 banks gated meanwhile", 32'(bank_irq), 32'h0);
    endtask

    task automatic t_collision();
        @(negedge clk);
        pin_in  = 32'h0010_0000;
        wr_en   = 1'b1; wr_addr = A_ST; wr_data = 32'h0000_000C;
        @(negedge clk);
        wr_en = 1'b0;
        rd_chk("R9 event beats same-cycle clear", A_ST, 32'h0000_0008);
    endtask

    task automatic t_reset_again();
        do_reset();
        rd_chk("R10 status after reset", A_ST, 32'h0);
        rd_chk("R10 rise mask after reset", A_RS, 32'h0);
        rd_chk("R10 fall mask after reset", A_FS, 32'h0);
        check("R10 outputs after reset", {30'h0, bank_irq} | 32'(pin_irq), 32'h0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_enables();
        t_single_edges();
        t_both_edges();
        t_w1c();
        t_banks();
        t_level();
        t_direct();
        t_collision();
        t_reset_again();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule